// File: doc/BRIEF.md
# Memory Operation Buffer for an Out-of-Order Core

This block parks the loads and stores of a dynamically scheduled core while their operands and the memory port catch up with them. A load is accepted with a base operand, given either as a value or as the tag of the unit that will produce it, and a signed immediate offset. Once the base is known the entry forms its word address. It then waits for a safe moment to read memory and afterwards holds the returned value until the result bus arbiter grants it a slot. Every load entry has a fixed tag, and consumers elsewhere in the core wait on that tag.

A store is accepted the same way. Its data operand may also be pending behind a tag. Store entries watch the shared result bus and pick up their base or data when a matching producer tag is broadcast. When both address and data are known and ordering allows, the store writes the memory in one access and leaves the buffer.

The memory is an internal single-port word array with a fixed access latency. Ordering is conservative. A load waits for every older store whose address is unknown or equal to its own. A store waits for every older store and every older load that has not yet read memory.

Top module: `mem_op_buffer`

## Requirements
- R1: After reset all entries are empty: `ld_free` and `st_free` are 1, `ld_req` is 0, and `ld_new_tag` equals `LD_TAG_BASE`.
- R2: `ld_free` / `st_free` are 1 exactly when a load / store entry is empty. A new load takes the lowest empty slot s and carries tag `LD_TAG_BASE + s`, which `ld_new_tag` shows before issue. An issue request of a kind with no empty slot is ignored.
- R3: The word address is the low `ADDR_W` bits of base plus the `IMM_W`-bit immediate sign-extended. A base tag of 0 means `iss_base_val` is the base. Otherwise the base is `bus_data` from the first cycle, the issue cycle included, in which `bus_valid` is 1 and `bus_tag` equals that tag.
- R4: A load issued with a known address while memory is idle and no store is eligible first raises `ld_req` after the (MEM_LAT+1)-th rising edge following its issue edge.
- R5: Memory performs one access at a time, and each access occupies it for `MEM_LAT` cycles. Of two loads made ready in the same cycle, the second raises `ld_req` MEM_LAT+1 cycles after the first.
- R6: A store takes its data from `iss_data_val` when the data tag is 0, else from the bus by tag. It writes memory once both address and data are known, and its entry is freed in that cycle.
- R7: Stores write memory in issue order. No store writes before every load issued ahead of it has read memory.
- R8: A load does not read memory while an older store has an unknown address or an address equal to its own. An older store with a known, different address does not hold it back.
- R9: `ld_req` presents the lowest-index entry holding a returned value, with its tag and data. It stays high until `ld_grant`, and the granted entry is freed at that edge.
- R10: The bus is ignored in cycles where `bus_valid` is 0 and by entries whose pending tag differs from `bus_tag`. Tag 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_base_tag | input | TAG_W | Producer tag of the base, 0 = value present |
| iss_base_val | input | DATA_W | Base value when the tag is 0 |
| iss_imm | input | IMM_W | Signed address offset |
| iss_data_tag | input | TAG_W | Producer tag of store data, 0 = value present |
| iss_data_val | input | DATA_W | Store data when the tag is 0 |
| ld_free | output | 1 | A load entry is empty |
| st_free | output | 1 | A store entry is empty |
| ld_new_tag | output | TAG_W | Tag the next accepted load will receive |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Producer tag of the broadcast |
| bus_data | input | DATA_W | Broadcast value |
| ld_req | output | 1 | A load value awaits the result bus |
| ld_req_tag | output | TAG_W | Tag of the requesting load |
| ld_req_data | output | DATA_W | Value of the requesting load |
| ld_grant | input | 1 | Bus granted to the presented load |

## Verification
The bench builds the block with two load entries, two store entries and a three-cycle memory latency. With these values both kinds of buffer fill after two issues, so the ignored third issue and the full flags are cheap to reach. The longer latency leaves clear gaps in which a blocked or busy entry can be seen to stay silent, and it separates the two request times of back-to-back loads by a measurable four cycles. The default tag, data, address and offset widths are kept, so negative offsets and address wrap-around at sixteen words are exercised as well.

// File: rtl/mem_op_buffer.sv
module mem_op_buffer #(
  parameter int NLD         = 3,
  parameter int NST         = 2,
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int IMM_W       = 6,
  parameter int MEM_LAT     = 2,
  parameter int LD_TAG_BASE = 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_store,
  input  logic [TAG_W-1:0]  iss_base_tag,
  input  logic [DATA_W-1:0] iss_base_val,
  input  logic [IMM_W-1:0]  iss_imm,
  input  logic [TAG_W-1:0]  iss_data_tag,
  input  logic [DATA_W-1:0] iss_data_val,
  output logic              ld_free,
  output logic              st_free,
  output logic [TAG_W-1:0]  ld_new_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ld_req,
  output logic [TAG_W-1:0]  ld_req_tag,
  output logic [DATA_W-1:0] ld_req_data,
  input  logic              ld_grant
);
  localparam int LIW   = (NLD > 1) ? $clog2(NLD) : 1;
  localparam int SIW   = (NST > 1) ? $clog2(NST) : 1;
  localparam int CW    = $clog2(MEM_LAT + 1);
  localparam int WORDS = 1 << ADDR_W;
  localparam logic [2:0] L_FREE = 3'd0, L_ADDR = 3'd1, L_PEND = 3'd2, L_MEM = 3'd3, L_RDY = 3'd4;

  function automatic logic [ADDR_W-1:0] ea(input logic [DATA_W-1:0] b, input logic [IMM_W-1:0] imm);
    logic [DATA_W+IMM_W-1:0] s;
    s = {{DATA_W{imm[IMM_W-1]}}, imm};
    return b[ADDR_W-1:0] + s[ADDR_W-1:0];
  endfunction

  logic [DATA_W-1:0] mem [WORDS];
  logic [CW-1:0]     mem_cnt;

  logic [2:0]        ld_st   [NLD];
  logic [TAG_W-1:0]  ld_btag [NLD];
  logic [IMM_W-1:0]  ld_imm  [NLD];
  logic [ADDR_W-1:0] ld_addr [NLD];
  logic [DATA_W-1:0] ld_val  [NLD];
  logic [NST-1:0]    ld_old  [NLD];

  logic [NST-1:0]    st_busy, st_ak, st_dk;
  logic [TAG_W-1:0]  st_btag [NST];
  logic [IMM_W-1:0]  st_imm  [NST];
  logic [ADDR_W-1:0] st_addr [NST];
  logic [TAG_W-1:0]  st_dtag [NST];
  logic [DATA_W-1:0] st_dval [NST];
  logic [NST-1:0]    st_old  [NST];
  logic [NLD-1:0]    st_ldold[NST];

  logic [NLD-1:0] ld_bhit, ld_go, ld_wait, ld_sent;
  logic [NST-1:0] st_bhit, st_dhit, st_go, st_clr;
  logic           iss_bhit, iss_dhit, mem_idle, st_send, ld_send;
  logic           ld_any_free, st_any_free, st_any_go, ld_any_go, rq_any;
  logic [LIW-1:0] ld_fi, ld_sel, rq_idx;
  logic [SIW-1:0] st_fi, st_sel;

  assign iss_bhit = bus_valid && iss_base_tag != '0 && bus_tag == iss_base_tag;
  assign iss_dhit = bus_valid && iss_data_tag != '0 && bus_tag == iss_data_tag;
  assign mem_idle = mem_cnt == '0;

  for (genvar j = 0; j < NST; j++) begin : g_st
    assign st_bhit[j] = bus_valid && st_btag[j] != '0 && bus_tag == st_btag[j];
    assign st_dhit[j] = bus_valid && st_dtag[j] != '0 && bus_tag == st_dtag[j];
    assign st_go[j]   = st_busy[j] && st_ak[j] && st_dk[j] &&
                        ((st_old[j] & st_busy) == '0) && (st_ldold[j] == '0);
  end

  for (genvar i = 0; i < NLD; i++) begin : g_ld
    logic [NST-1:0] blk;
    for (genvar j = 0; j < NST; j++) begin : g_blk
      assign blk[j] = ld_old[i][j] && st_busy[j] && (!st_ak[j] || st_addr[j] == ld_addr[i]);
    end
    assign ld_bhit[i] = bus_valid && ld_btag[i] != '0 && bus_tag == ld_btag[i];
    assign ld_go[i]   = ld_st[i] == L_PEND && blk == '0;
    assign ld_wait[i] = ld_st[i] == L_ADDR || ld_st[i] == L_PEND;
  end

  always_comb begin
    ld_any_free = 1'b0; ld_fi  = '0;
    st_any_free = 1'b0; st_fi  = '0;
    ld_any_go   = 1'b0; ld_sel = '0;
    st_any_go   = 1'b0; st_sel = '0;
    rq_any      = 1'b0; rq_idx = '0;
    for (int i = NLD - 1; i >= 0; i--) begin
      if (ld_st[i] == L_FREE) begin ld_any_free = 1'b1; ld_fi  = LIW'(i); end
      if (ld_go[i])           begin ld_any_go   = 1'b1; ld_sel = LIW'(i); end
      if (ld_st[i] == L_RDY)  begin rq_any      = 1'b1; rq_idx = LIW'(i); end
    end
    for (int j = NST - 1; j >= 0; j--) begin
      if (!st_busy[j]) begin st_any_free = 1'b1; st_fi  = SIW'(j); end
      if (st_go[j])    begin st_any_go   = 1'b1; st_sel = SIW'(j); end
    end
  end

  assign st_send = mem_idle && st_any_go;
  assign ld_send = mem_idle && !st_any_go && ld_any_go;
  assign st_clr  = st_send ? (NST'(1) << st_sel) : '0;
  assign ld_sent = ld_send ? (NLD'(1) << ld_sel) : '0;

  assign ld_free     = ld_any_free;
  assign st_free     = st_any_free;
  assign ld_new_tag  = TAG_W'(LD_TAG_BASE) + TAG_W'(ld_fi);
  assign ld_req      = rq_any;
  assign ld_req_tag  = TAG_W'(LD_TAG_BASE) + TAG_W'(rq_idx);
  assign ld_req_data = ld_val[rq_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cnt <= '0;
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      for (int i = 0; i < NLD; i++) begin
        ld_st[i] <= L_FREE; ld_btag[i] <= '0; ld_imm[i] <= '0;
        ld_addr[i] <= '0; ld_val[i] <= '0; ld_old[i] <= '0;
      end
      st_busy <= '0; st_ak <= '0; st_dk <= '0;
      for (int j = 0; j < NST; j++) begin
        st_btag[j] <= '0; st_imm[j] <= '0; st_addr[j] <= '0;
        st_dtag[j] <= '0; st_dval[j] <= '0; st_old[j] <= '0; st_ldold[j] <= '0;
      end
    end else begin
      if (st_send || ld_send) mem_cnt <= CW'(MEM_LAT);
      else if (!mem_idle)     mem_cnt <= mem_cnt - CW'(1);
      if (st_send) mem[st_addr[st_sel]] <= st_dval[st_sel];

      for (int i = 0; i < NLD; i++) begin
        ld_old[i] <= ld_old[i] & ~st_clr;
        case (ld_st[i])
          L_ADDR: if (ld_bhit[i]) begin
                    ld_addr[i] <= ea(bus_data, ld_imm[i]);
                    ld_st[i]   <= L_PEND;
                  end
          L_PEND: if (ld_sent[i]) begin
                    ld_val[i] <= mem[ld_addr[i]];
                    ld_st[i]  <= L_MEM;
                  end
          L_MEM:  if (mem_cnt == CW'(1)) ld_st[i] <= L_RDY;
          L_RDY:  if (ld_grant && rq_idx == LIW'(i)) ld_st[i] <= L_FREE;
          default: ;
        endcase
        if (iss_valid && !iss_store && ld_any_free && ld_fi == LIW'(i)) begin
          ld_btag[i] <= iss_base_tag;
          ld_imm[i]  <= iss_imm;
          ld_old[i]  <= st_busy & ~st_clr;
          if (iss_base_tag == '0) begin
            ld_addr[i] <= ea(iss_base_val, iss_imm); ld_st[i] <= L_PEND;
          end else if (iss_bhit) begin
            ld_addr[i] <= ea(bus_data, iss_imm);     ld_st[i] <= L_PEND;
          end else begin
            ld_st[i] <= L_ADDR;
          end
        end
      end

      for (int j = 0; j < NST; j++) begin
        st_old[j]   <= st_old[j] & ~st_clr;
        st_ldold[j] <= st_ldold[j] & ~ld_sent;
        if (st_busy[j] && !st_ak[j] && st_bhit[j]) begin
          st_addr[j] <= ea(bus_data, st_imm[j]); st_ak[j] <= 1'b1;
        end
        if (st_busy[j] && !st_dk[j] && st_dhit[j]) begin
          st_dval[j] <= bus_data; st_dk[j] <= 1'b1;
        end
        if (st_clr[j]) st_busy[j] <= 1'b0;
        if (iss_valid && iss_store && st_any_free && st_fi == SIW'(j)) begin
          st_busy[j]  <= 1'b1;
          st_btag[j]  <= iss_base_tag;
          st_imm[j]   <= iss_imm;
          st_dtag[j]  <= iss_data_tag;
          st_old[j]   <= st_busy & ~st_clr;
          st_ldold[j] <= ld_wait & ~ld_sent;
          st_ak[j]    <= iss_base_tag == '0 || iss_bhit;
          st_addr[j]  <= ea(iss_base_tag == '0 ? iss_base_val : bus_data, iss_imm);
          st_dk[j]    <= iss_data_tag == '0 || iss_dhit;
          st_dval[j]  <= iss_data_tag == '0 ? iss_data_val : bus_data;
        end
      end
    end
  end

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && !ld_grant |=> ld_req);

  assert_grant_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && ld_grant |=> ld_st[$past(rq_idx)] == L_FREE);

  assert_mem_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_idle |=> mem_cnt == $past(mem_cnt) - CW'(1));

  for (genvar i = 0; i < NLD; i++) begin : g_chk
    assert_rdy_after_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_st[i] == L_RDY && $past(ld_st[i]) != L_RDY) |-> $past(ld_st[i]) == L_MEM);
  end
endmodule

// File: tb/tb_mem_op_buffer.sv
`timescale 1ns/1ps
module tb_mem_op_buffer;
  localparam int NLD = 2, NST = 2, LAT = 3, TW = 4, DW = 16, AW = 4, IW = 6, TB = 1;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_store = 0, bus_valid = 0, ld_grant = 0;
  logic [TW-1:0] iss_base_tag = 0, iss_data_tag = 0, bus_tag = 0;
  logic [DW-1:0] iss_base_val = 0, iss_data_val = 0, bus_data = 0;
  logic [IW-1:0] iss_imm = 0;
  logic ld_free, st_free, ld_req;
  logic [TW-1:0] ld_new_tag, ld_req_tag;
  logic [DW-1:0] ld_req_data;

  mem_op_buffer #(.NLD(NLD), .NST(NST), .TAG_W(TW), .DATA_W(DW), .ADDR_W(AW),
                  .IMM_W(IW), .MEM_LAT(LAT), .LD_TAG_BASE(TB)) dut (
    .clk, .rst_n, .iss_valid, .iss_store, .iss_base_tag, .iss_base_val, .iss_imm,
    .iss_data_tag, .iss_data_val, .ld_free, .st_free, .ld_new_tag, .bus_valid,
    .bus_tag, .bus_data, .ld_req, .ld_req_tag, .ld_req_data, .ld_grant);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] tbm [1 << AW];

  localparam int V_SB [6] = '{2, 10, 15, 7, 'h0F30, 4};
  localparam int V_SI [6] = '{3, -4, 2, 7, -1, -20};
  localparam int V_LB [6] = '{5, 3, 'h0100, 9, 12, 6};
  localparam int V_LI [6] = '{0, 3, 1, -2, 3, -22};
  localparam int V_D  [6] = '{'h1111, 'h2222, 'h3333, 'h4444, 'h5555, 'h6666};

  function automatic int eat(input int b, input int imm);
    return (b + imm) & ((1 << AW) - 1);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_ld(input int bt, input int bv, input int imm);
    iss_valid = 1; iss_store = 0; iss_base_tag = TW'(bt); iss_base_val = DW'(bv); iss_imm = IW'(imm);
    @(negedge clk); iss_valid = 0;
  endtask

  task automatic do_st(input int bt, input int bv, input int imm, input int dt, input int dv);
    iss_valid = 1; iss_store = 1; iss_base_tag = TW'(bt); iss_base_val = DW'(bv); iss_imm = IW'(imm);
    iss_data_tag = TW'(dt); iss_data_val = DW'(dv);
    @(negedge clk); iss_valid = 0; iss_store = 0;
  endtask

  task automatic bcast(input int t, input int d);
    bus_valid = 1; bus_tag = TW'(t); bus_data = DW'(d);
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic wait_req(input int maxc, output bit got);
    got = 0;
    for (int k = 0; k < maxc && !got; k++) begin
      if (ld_req) got = 1; else @(negedge clk);
    end
  endtask

  task automatic grant_chk(input string rq, input int tag, input logic [DW-1:0] d);
    chk(ld_req == 1, rq, ld_req, 1);
    chk(ld_req_tag == TW'(tag), rq, ld_req_tag, tag);
    chk(ld_req_data == d, rq, ld_req_data, d);
    ld_grant = 1; @(negedge clk); ld_grant = 0;
  endtask

  task automatic load_expect(input string rq, input int bv, input int imm);
    bit got;
    do_ld(0, bv, imm);
    wait_req(60, got);
    chk(got, rq, got, 1);
    grant_chk(rq, TB, tbm[eat(bv, imm)]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit got;
    int n;
    for (int w = 0; w < (1 << AW); w++) tbm[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(ld_free == 1 && st_free == 1, "R1 free flags", {ld_free, st_free}, 2'b11);
    chk(ld_req == 0, "R1 no request", ld_req, 0);
    chk(ld_new_tag == TW'(TB), "R1 new tag", ld_new_tag, TB);

    for (int v = 0; v < 6; v++) begin
      chk(ld_new_tag == TW'(TB), "R2 lowest slot tag", ld_new_tag, TB);
      do_st(0, V_SB[v], V_SI[v], 0, V_D[v]);
      tbm[eat(V_SB[v], V_SI[v])] = DW'(V_D[v]);
      load_expect("R3 R6 R8 table vector", V_LB[v], V_LI[v]);
    end

    // R4: exact latency
    do_ld(0, 6, 0);
    repeat (LAT) @(negedge clk);
    chk(ld_req == 0, "R4 not before latency", ld_req, 0);
    @(negedge clk);
    chk(ld_req == 1, "R4 at latency", ld_req, 1);
    grant_chk("R4 value", TB, tbm[6]);

    // R10: invalid or foreign broadcasts ignored
    do_ld(9, 0, 3);
    bus_valid = 0; bus_tag = 9; bus_data = 16'h0007;
    repeat (5) @(negedge clk);
    bcast(10, 2);
    repeat (12) @(negedge clk);
    chk(ld_req == 0, "R10 bus ignored", ld_req, 0);
    bcast(9, 'h0032);
    wait_req(30, got);
    grant_chk("R10 R3 base by tag", TB, tbm[eat('h32, 3)]);

    // R3: base captured in the issue cycle
    iss_valid = 1; iss_store = 0; iss_base_tag = 13; iss_base_val = 0; iss_imm = IW'(-1);
    bus_valid = 1; bus_tag = 13; bus_data = 16'h0004;
    @(negedge clk); iss_valid = 0; bus_valid = 0;
    wait_req(30, got);
    chk(got, "R3 same-cycle capture", got, 1);
    grant_chk("R3 same-cycle value", TB, tbm[3]);

    // R2 full, R9 order and hold
    do_ld(8, 0, 7);
    chk(ld_new_tag == TW'(TB + 1), "R2 second slot tag", ld_new_tag, TB + 1);
    do_ld(8, 0, 8);
    chk(ld_free == 0, "R2 load full", ld_free, 0);
    do_ld(0, 1, 1);
    bcast(8, 0);
    repeat (2 * (LAT + 1) + 4) @(negedge clk);
    chk(ld_req_tag == TW'(TB), "R9 lowest first", ld_req_tag, TB);
    repeat (3) @(negedge clk);
    grant_chk("R9 held until grant", TB, tbm[7]);
    grant_chk("R9 next entry", TB + 1, tbm[8]);
    repeat (20) @(negedge clk);
    chk(ld_req == 0, "R2 full issue ignored", ld_req, 0);

    // R5: single port spacing
    do_ld(14, 0, 1);
    do_ld(14, 0, 2);
    bcast(14, 4);
    wait_req(30, got);
    grant_chk("R5 first", TB, tbm[5]);
    n = 1;
    while (!ld_req && n < 50) begin @(negedge clk); n++; end
    chk(n == LAT + 1, "R5 spacing", n, LAT + 1);
    grant_chk("R5 second", TB + 1, tbm[6]);

    // R8: unknown then equal address blocks
    do_st(12, 0, 1, 13, 0);
    do_ld(0, 10, 0);
    repeat (12) @(negedge clk);
    chk(ld_req == 0, "R8 unknown address blocks", ld_req, 0);
    bcast(12, 9);
    repeat (12) @(negedge clk);
    chk(ld_req == 0, "R8 equal address blocks", ld_req, 0);
    bcast(13, 'h7777);
    tbm[10] = 16'h7777;
    wait_req(30, got);
    grant_chk("R8 R6 forwarded through memory", TB, tbm[10]);

    // R8: known different address does not block
    do_st(0, 9, 0, 15, 0);
    do_ld(0, 4, 0);
    wait_req(20, got);
    chk(got, "R8 different address proceeds", got, 1);
    grant_chk("R8 different address value", TB, tbm[4]);
    bcast(15, 'h9999);
    tbm[9] = 16'h9999;
    load_expect("R6 data by tag", 9, 0);

    // R7: store waits for older load
    do_ld(11, 0, 2);
    do_st(0, 12, 0, 0, 'hBEEF);
    repeat (15) @(negedge clk);
    chk(ld_req == 0, "R7 load still waits for base", ld_req, 0);
    bcast(11, 10);
    wait_req(30, got);
    grant_chk("R7 older load sees old value", TB, tbm[12]);
    tbm[12] = 16'hBEEF;
    load_expect("R7 store then lands", 12, 0);

    // R7: stores in order
    do_st(0, 13, 0, 12, 0);
    do_st(0, 13, 0, 0, 'hAAAA);
    chk(st_free == 0, "R2 store full", st_free, 0);
    repeat (10) @(negedge clk);
    bcast(12, 'h5555);
    tbm[13] = 16'hAAAA;
    repeat (2 * LAT + 4) @(negedge clk);
    chk(st_free == 1, "R6 stores drained", st_free, 1);
    load_expect("R7 younger store last", 13, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule